// File: doc/BRIEF.md
# Matrix Keypad Scan-Result Controller

This block is the register-side half of an 8x8 matrix keypad controller. Software talks to it over a simple 32-bit register bus. The bus gives access to these registers:

- a control word;
- a direct-key word;
- a rotary status word;
- a matrix-key word;
- an auto-scan word;
- four scan-result words;
- a debounce interval word.

Key events arrive on a separate port. Each event carries a 7-bit key code, a release flag and a one-cycle strobe. A combinational key map splits the code into a row and a column, or flags the code as unmapped.

When matrix scanning is enabled and a scan mode is armed, an event updates the result words. A press sets one bit. A release wipes the word that holds the key's column pair. If matrix interrupts are enabled, the event also raises a level interrupt. Software acknowledges the interrupt by reading the control word. Some status bits clear themselves when read.

The interrupt line is governed by a two-state machine:

- State IRQ_IDLE moves to IRQ_PENDING on the transition RAISE, which is a handled event with interrupts enabled.
- IRQ_PENDING returns to IRQ_IDLE on the transition ACK, which is a control-word read in a cycle with no new raise.
- In every other case the state holds (HOLD).

Top module: `kpad_matrix_ctrl`

## Requirements
- R1: After reset every defined register reads zero, and both `irq` and `bus_err` are low.
- R2: A write to a defined byte offset stores all 32 bits into that register. The defined offsets are 0x00 control, 0x08 direct key, 0x10 rotary, 0x18 matrix key, 0x20 auto-scan, 0x28/0x30/0x38/0x40 result words 0..3, and 0x48 debounce. Read data appears on `bus_rdata` in the cycle after the read is sampled.
- R3: Key events change nothing while control bit 12 (matrix enable) is clear.
- R4: An event is handled only when control bit 30 (single auto-scan) or bit 29 (scan on activity) is set. Bit 30 clears itself when an event is handled; bit 29 stays.
- R5: Key code bits [2:0] give the row and bits [5:3] give the column. A press sets bit row + 16*(col mod 2) in result word col/2.
- R6: A release (flag high) clears to zero the whole result word covering that column pair. The other result words are untouched.
- R7: A key code with bit 6 set is unmapped. Its event changes no register and raises no interrupt.
- R8: A handled event with control bit 11 (matrix interrupt enable) set sets control bit 22 and asserts `irq` one cycle later. With bit 11 clear, neither happens.
- R9: A control read returns the value before the read. It then clears bits 22 and 5 and drops `irq`.
- R10: A rotary read returns the old value, then clears bits 31, 30, 15 and 14. A matrix-key read returns the old value, then clears bit 31.
- R11: An access to any other offset reads zero and is ignored on write. It pulses `bus_err` for one cycle, one cycle after the access.
- R12: When a control read and a handled event fall in the same cycle, the event's bit sets take effect after the read's clears. Bit 22 and `irq` therefore remain set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | One-cycle pulse after an access to an undefined offset |
| key_stb | input | 1 | Key event strobe |
| key_code | input | 7 | Key code of the event |
| key_release | input | 1 | High for a release, low for a press |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a control read that lands in the same cycle as a handled key event. In that cycle the acknowledge and a fresh raise compete for both bit 22 and the interrupt state. The bench first raises the interrupt with one press. It then drives a read strobe and a second press on the same clock edge. It expects the old control value back, and it expects the interrupt still asserted until a later, solitary control read.

// File: rtl/kpad_pkg.sv
package kpad_pkg;

    // Control word bit positions
    localparam int B_AS    = 30;
    localparam int B_ASACT = 29;
    localparam int B_MINT  = 22;
    localparam int B_ME    = 12;
    localparam int B_MIE   = 11;
    localparam int B_DINT  = 5;

    // Self-clearing status bits
    localparam int B_ROT_OF1 = 31;
    localparam int B_ROT_UF1 = 30;
    localparam int B_ROT_OF0 = 15;
    localparam int B_ROT_UF0 = 14;
    localparam int B_MK_HIT  = 31;

    // Fixed word indices; the result words follow IDX_SCAN
    localparam int IDX_CTRL = 0;
    localparam int IDX_DKEY = 1;
    localparam int IDX_ROT  = 2;
    localparam int IDX_MK   = 3;
    localparam int IDX_SCAN = 4;

    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_t;

endpackage

// File: rtl/kpad_keymap.sv
module kpad_keymap #(
    parameter int CODE_W = 7,
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3
) (
    input  logic [CODE_W-1:0] code,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic              valid
);
    // Top code bit marks a key outside the matrix
    always_comb begin
        row   = code[ROW_W-1:0];
        col   = code[ROW_W +: COL_W];
        valid = ~code[CODE_W-1];
    end
endmodule

// File: rtl/kpad_irq_fsm.sv
module kpad_irq_fsm
    import kpad_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack,
    output logic irq
);
    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:    if (raise)         state_d = IRQ_PENDING;
            IRQ_PENDING: if (ack && !raise) state_d = IRQ_IDLE;
            default:                        state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_PENDING);
    end
endmodule

// File: rtl/kpad_regbank.sv
module kpad_regbank
    import kpad_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int ROW_W    = 3,
    parameter int COL_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_err,
    input  logic              ev_stb,
    input  logic              ev_release,
    input  logic              ev_valid,
    input  logic [ROW_W-1:0]  ev_row,
    input  logic [COL_W-1:0]  ev_col,
    output logic              ev_irq_set,
    output logic              ctrl_rd,
    output logic [DATA_W-1:0] ctrl_word
);
    localparam int NUM_COLS = 1 << COL_W;
    localparam int NUM_RES  = NUM_COLS / 2;
    localparam int RES_BASE = IDX_SCAN + 1;
    localparam int IDX_DEB  = RES_BASE + NUM_RES;
    localparam int NREG     = IDX_DEB + 1;
    localparam int WORD_W   = ADDR_W - 3;
    localparam int HALF     = DATA_W / 2;

    logic [DATA_W-1:0] regs_q [NREG];
    logic [DATA_W-1:0] regs_d [NREG];

    logic [WORD_W-1:0] word;
    logic              hit;
    int                idx;
    logic              ev_ok;
    int                res_i;
    logic [DATA_W-1:0] press_mask;

    always_comb begin
        word  = addr[ADDR_W-1:3];
        hit   = (addr[2:0] == 3'd0) && (int'(word) < NREG);
        idx   = hit ? int'(word) : 0;
        ev_ok = ev_stb && ev_valid && regs_q[IDX_CTRL][B_ME] &&
                (regs_q[IDX_CTRL][B_AS] || regs_q[IDX_CTRL][B_ASACT]);
        res_i = RES_BASE + int'(ev_col >> 1);
        press_mask = '0;
        press_mask[int'(ev_row) + (ev_col[0] ? HALF : 0)] = 1'b1;
    end

    always_comb begin
        for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
        if (wr_en && hit) regs_d[idx] = wdata;
        // Read-side clears come first
        if (rd_en && hit) begin
            unique case (idx)
                IDX_CTRL: begin
                    regs_d[IDX_CTRL][B_MINT] = 1'b0;
                    regs_d[IDX_CTRL][B_DINT] = 1'b0;
                end
                IDX_ROT: begin
                    regs_d[IDX_ROT][B_ROT_OF1] = 1'b0;
                    regs_d[IDX_ROT][B_ROT_UF1] = 1'b0;
                    regs_d[IDX_ROT][B_ROT_OF0] = 1'b0;
                    regs_d[IDX_ROT][B_ROT_UF0] = 1'b0;
                end
                IDX_MK:  regs_d[IDX_MK][B_MK_HIT] = 1'b0;
                default: ;
            endcase
        end
        // Then the event's updates
        if (ev_ok) begin
            if (regs_q[IDX_CTRL][B_AS]) regs_d[IDX_CTRL][B_AS] = 1'b0;
            if (ev_release) regs_d[res_i] = '0;
            else            regs_d[res_i] = regs_d[res_i] | press_mask;
            if (regs_q[IDX_CTRL][B_MIE]) regs_d[IDX_CTRL][B_MINT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
            rdata   <= '0;
            bus_err <= 1'b0;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
            if (rd_en) rdata <= hit ? regs_q[idx] : '0;
            bus_err <= (rd_en || wr_en) && !hit;
        end
    end

    always_comb begin
        ev_irq_set = ev_ok && regs_q[IDX_CTRL][B_MIE];
        ctrl_rd    = rd_en && hit && (idx == IDX_CTRL);
        ctrl_word  = regs_q[IDX_CTRL];
    end
endmodule

// File: rtl/kpad_matrix_ctrl.sv
module kpad_matrix_ctrl #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    localparam int CODE_W = ROW_W + COL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic              key_stb,
    input  logic [CODE_W-1:0] key_code,
    input  logic              key_release,
    output logic              irq
);
    logic [ROW_W-1:0]  ev_row;
    logic [COL_W-1:0]  ev_col;
    logic              ev_valid;
    logic              ev_irq_set;
    logic              ctrl_rd;
    logic [DATA_W-1:0] ctrl_word;

    kpad_keymap #(.CODE_W(CODE_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_map (
        .code  (key_code),
        .row   (ev_row),
        .col   (ev_col),
        .valid (ev_valid)
    );

    kpad_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .rd_en      (bus_rd),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .bus_err    (bus_err),
        .ev_stb     (key_stb),
        .ev_release (key_release),
        .ev_valid   (ev_valid),
        .ev_row     (ev_row),
        .ev_col     (ev_col),
        .ev_irq_set (ev_irq_set),
        .ctrl_rd    (ctrl_rd),
        .ctrl_word  (ctrl_word)
    );

    kpad_irq_fsm u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (ev_irq_set),
        .ack   (ctrl_rd),
        .irq   (irq)
    );
endmodule

// File: rtl/kpad_matrix_ctrl_chk.sv
module kpad_matrix_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              key_stb,
    input logic              key_unmapped,
    input logic              ctrl_me,
    input logic              ctrl_as,
    input logic              ctrl_asact,
    input logic              ctrl_mie,
    input logic              ctrl_mint,
    input logic              bus_err,
    input logic              irq
);
    logic handled, bad_access, quiet_bus;
    always_comb begin
        handled    = key_stb && !key_unmapped && ctrl_me && (ctrl_as || ctrl_asact);
        bad_access = (bus_rd || bus_wr) &&
                     ((bus_addr[2:0] != 3'd0) || (bus_addr[ADDR_W-1:3] > 9));
        quiet_bus  = !bus_rd && !bus_wr;
    end

    a_r8_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        handled && ctrl_mie |=> irq && ctrl_mint);

    a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == '0 && !(handled && ctrl_mie) |=> !irq);

    a_r3_disabled_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        key_stb && !ctrl_me && quiet_bus |=> irq == $past(irq));

    a_r7_unmapped_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        key_stb && key_unmapped && quiet_bus |=> irq == $past(irq));

    a_r4_as_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        handled && ctrl_as && !bus_wr |=> !ctrl_as);

    a_r11_err_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |=> bus_err);

    a_r11_err_only_bad: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_access |=> !bus_err);
endmodule

bind kpad_matrix_ctrl kpad_matrix_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .key_stb      (key_stb),
    .key_unmapped (key_code[ROW_W+COL_W]),
    .ctrl_me      (ctrl_word[12]),
    .ctrl_as      (ctrl_word[30]),
    .ctrl_asact   (ctrl_word[29]),
    .ctrl_mie     (ctrl_word[11]),
    .ctrl_mint    (ctrl_word[22]),
    .bus_err      (bus_err),
    .irq          (irq)
);

// File: tb/kpad_matrix_ctrl_bench.sv
`timescale 1ns/1ps
module kpad_matrix_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        key_stb = 1'b0;
    logic [6:0]  key_code = '0;
    logic        key_release = 1'b0;
    logic        irq;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [31:0] q_data[$];
    logic        q_err[$];
    bit          q_chk[$];
    string       q_tag[$];
    logic        mon_arm = 1'b0;

    always #10 clk = ~clk;

    kpad_matrix_ctrl u_kpad_matrix_ctrl (.*);

    // Control bit constants
    localparam logic [31:0] AS = 32'h4000_0000, ACT = 32'h2000_0000;
    localparam logic [31:0] MINT = 32'h0040_0000, ME = 32'h0000_1000;
    localparam logic [31:0] MIE = 32'h0000_0800, DINT = 32'h0000_0020;

    always @(posedge clk) mon_arm <= bus_rd || bus_wr;

    // Monitor: pop expected results as the design produces them
    always @(negedge clk) begin
        if (mon_arm && q_tag.size() > 0) begin
            logic [31:0] ed; logic ee; bit ec; string t;
            ed = q_data.pop_front(); ee = q_err.pop_front();
            ec = q_chk.pop_front();  t  = q_tag.pop_front();
            checks++;
            if (bus_err !== ee) begin
                failures++;
                $display("FAIL %s err actual=%0b expected=%0b", t, bus_err, ee);
            end
            if (ec) begin
                checks++;
                if (bus_rdata !== ed) begin
                    failures++;
                    $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata, ed);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic ee, input string t);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        q_data.push_back('0); q_err.push_back(ee); q_chk.push_back(0); q_tag.push_back(t);
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input logic ee, input string t);
        bus_rd = 1; bus_addr = a;
        q_data.push_back(exp); q_err.push_back(ee); q_chk.push_back(1); q_tag.push_back(t);
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic key(input logic [6:0] c, input logic rel);
        key_stb = 1; key_code = c; key_release = rel;
        @(negedge clk); key_stb = 0; key_release = 0;
    endtask

    task automatic chk_irq(input logic exp, input string t);
        checks++;
        if (irq !== exp) begin
            failures++;
            $display("FAIL %s irq actual=%0b expected=%0b", t, irq, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk_irq(0, "R1");
        checks++;
        if (bus_err !== 1'b0) begin
            failures++;
            $display("FAIL R1 err actual=%0b expected=0", bus_err);
        end
        for (int i = 0; i < 10; i++) rd(8'(i*8), 32'h0, 0, "R1");

        // R2 full-width write/readback on offsets 0x08..0x48
        for (int i = 1; i < 10; i++) wr(8'(i*8), 32'hA5C3_0000 | 32'(i*32'h1111), 0, "R2");
        for (int i = 1; i < 10; i++) rd(8'(i*8), 32'hA5C3_0000 | 32'(i*32'h1111), 0, "R2");
        for (int i = 1; i < 10; i++) wr(8'(i*8), 32'h0, 0, "R2");

        // R11 undefined offsets
        wr(8'h50, 32'hFFFF_FFFF, 1, "R11");
        rd(8'h50, 32'h0, 1, "R11");
        wr(8'h04, 32'h1234_5678, 1, "R11");
        rd(8'h04, 32'h0, 1, "R11");
        rd(8'h08, 32'h0, 0, "R11");

        // R3 matrix disabled: event ignored
        wr(8'h00, AS | ACT | MIE, 0, "R3");
        key(7'h09, 0);
        chk_irq(0, "R3");
        rd(8'h28, 32'h0, 0, "R3");
        rd(8'h00, AS | ACT | MIE, 0, "R3");

        // R4 no scan mode: event ignored
        wr(8'h00, ME | MIE, 0, "R4");
        key(7'h09, 0);
        chk_irq(0, "R4");
        rd(8'h28, 32'h0, 0, "R4");

        // R4/R5/R8: single auto-scan press row1 col1 -> word0 bit17
        wr(8'h00, ME | AS | MIE, 0, "R4");
        key(7'h09, 0);
        chk_irq(1, "R8");
        rd(8'h28, 32'h0002_0000, 0, "R5");
        // R9: control read returns old value, clears bit22, drops irq
        rd(8'h00, ME | MIE | MINT, 0, "R9");
        chk_irq(0, "R9");
        rd(8'h00, ME | MIE, 0, "R9");
        // R4: bit30 now clear, so another event is ignored
        key(7'h00, 0);
        rd(8'h28, 32'h0002_0000, 0, "R4");

        // Scan on activity without interrupt enable
        wr(8'h00, ME | ACT, 0, "R8");
        key(7'h35, 0);          // row5 col6 -> word3 bit5
        key(7'h3A, 0);          // row2 col7 -> word3 bit18
        key(7'h27, 0);          // row7 col4 -> word2 bit7
        chk_irq(0, "R8");
        rd(8'h40, 32'h0004_0020, 0, "R5");
        rd(8'h38, 32'h0000_0080, 0, "R5");
        rd(8'h00, ME | ACT, 0, "R8");

        // R6 release wipes only its word
        key(7'h3A, 1);
        rd(8'h40, 32'h0, 0, "R6");
        rd(8'h38, 32'h0000_0080, 0, "R6");
        rd(8'h28, 32'h0002_0000, 0, "R6");

        // R7 unmapped code
        wr(8'h00, ME | ACT | MIE, 0, "R7");
        key(7'h45, 0);
        chk_irq(0, "R7");
        rd(8'h28, 32'h0002_0000, 0, "R7");
        rd(8'h38, 32'h0000_0080, 0, "R7");
        rd(8'h00, ME | ACT | MIE, 0, "R7");

        // R10 clear-on-read status words
        wr(8'h10, 32'hC000_C0FF, 0, "R10");
        rd(8'h10, 32'hC000_C0FF, 0, "R10");
        rd(8'h10, 32'h0000_00FF, 0, "R10");
        wr(8'h18, 32'h8000_0123, 0, "R10");
        rd(8'h18, 32'h8000_0123, 0, "R10");
        rd(8'h18, 32'h0000_0123, 0, "R10");

        // R9 direct interrupt bit cleared by control read
        wr(8'h00, ME | ACT | MIE | DINT, 0, "R9");
        rd(8'h00, ME | ACT | MIE | DINT, 0, "R9");
        rd(8'h00, ME | ACT | MIE, 0, "R9");

        // R12 read and event in one cycle
        key(7'h00, 0);          // row0 col0 -> word0 bit0
        chk_irq(1, "R12");
        bus_rd = 1; bus_addr = 8'h00; key_stb = 1; key_code = 7'h01; key_release = 0;
        q_data.push_back(ME | ACT | MIE | MINT); q_err.push_back(0);
        q_chk.push_back(1); q_tag.push_back("R12");
        @(negedge clk); bus_rd = 0; key_stb = 0;
        chk_irq(1, "R12");
        rd(8'h00, ME | ACT | MIE | MINT, 0, "R12");
        chk_irq(0, "R12");
        rd(8'h28, 32'h0002_0003, 0, "R12");

        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule